// File: doc/BRIEF.md
# Password-Guarded Watchdog Timer

This block is a watchdog built around a 16-bit up-counter. A prescaler divides the bus clock by one of two ratios, chosen by a control bit. Software services the watchdog with two bus writes. The first write carries a key, made of a fixed nibble and a nibble that software itself defined earlier. The second write carries guard bits. Only a good second write may change the reload value, the init-protection flag, the stop request, the prescaler choice or the user key. Every good second write restarts the counter.

There are three operating modes. In normal mode the counter restarts from the reload value that software wrote. Clearing the init-protection flag puts the block in time-out mode, and any access error puts it in prewarning mode. Both of these modes restart the counter from a fixed value set by a parameter. A wrong key or a bad guard word cannot be undone: the counter runs from the fixed value and requests a reset when it overflows. A plain overflow in normal or time-out mode also requests a reset. A two-bit flag output shows which of the two causes raised the request. Software may stop the counter in normal mode, but key and guard checking stay active while it is stopped.

Top module: `guarded_wdog`

## Requirements
- R1: After reset the block is in normal mode (mode code 0), the init flag is 1, the count is 0, the reset request is 0 and the error flags are 2'b00.
- R2: When the access FSM is idle, a write is a valid first access only if bits [15:12] equal 4'hA and bits [11:8] equal the stored user key, which is 0 after reset. A valid first access changes no output.
- R3: A first access with any other key moves the block to prewarning mode (code 2) and loads the fixed reload value into the count. No reset request is raised at that moment.
- R4: The write that follows a valid first access is a modify access. Its guard is good only if bits [15:12] equal 4'h5 and bits [7:3] are zero. A bad guard moves the block to prewarning mode and loads the fixed value.
- R5: A good modify access with bit 0 set selects normal mode. It sets the init flag and loads the count from bits [31:16], which also become the stored reload value.
- R6: A good modify access with bit 0 clear selects time-out mode (code 1). It clears the init flag and loads the fixed value. A later good modify access with bit 0 set returns the block to normal mode before any overflow.
- R7: The count increases by one after every 256 enabled bus cycles when bit 2 of the last modify access was 0, and after every 16384 enabled bus cycles when that bit was 1. The count does not change while the clock enable is low.
- R8: If the count is 16'hFFFF when a tick arrives in normal or time-out mode, the reset request goes high and the error flags become 2'b10. From then on the request stays high, the count is frozen and writes have no effect.
- R9: An overflow in prewarning mode raises the reset request with error flags 2'b01. While in prewarning mode, every write is ignored, including a correct key followed by a correct guard word.
- R10: Bit 1 of a modify access stops the counter in normal mode. A wrong key still moves the block to prewarning mode, and the counter then runs.
- R11: Bits [11:8] of a good modify access become the new user key. A later first access must match this new key.
- R12: After a modify access, good or bad, the access FSM is idle again. A guard-formatted write that comes without a preceding key is therefore treated as a wrong key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Bus clock enable feeding the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| count_o | output | 16 | Current counter value |
| mode_o | output | 2 | Mode code: 0 normal, 1 time-out, 2 prewarning |
| endinit_o | output | 1 | Init-protection flag |
| rst_req_o | output | 1 | Reset request, held until reset |
| err_o | output | 2 | Cause of the request: 2'b01 access error, 2'b10 overflow |

## Verification
A sequence of writes, made with the clock enable held low, walks the access FSM through good key/guard pairs in both init-flag settings, a change of the user key, the old key then being rejected, and writes in prewarning mode that must be ignored. This separates key checking, guard checking, reload selection and write locking without any counting getting in the way. Directed runs then count up to exact tick and overflow boundaries for each prescaler ratio and each mode. These runs tell the two error-flag codes apart, show that time-out can be rescued before overflow, and show that a stopped counter still reacts to a bad key.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_TIMEOUT = 2'd1,
    MODE_PREWARN = 2'd2
  } wdg_mode_t;

  typedef enum logic {
    ACC_IDLE = 1'b0,
    ACC_OPEN = 1'b1
  } acc_state_t;

  localparam logic [3:0] KEY_FIXED = 4'hA;
  localparam logic [3:0] GUARD_KEY = 4'h5;
  localparam int unsigned BIT_INIT = 0;
  localparam int unsigned BIT_STOP = 1;
  localparam int unsigned BIT_PSEL = 2;
  localparam logic [1:0] ERR_ACCESS = 2'b01;
  localparam logic [1:0] ERR_OVFL   = 2'b10;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int unsigned DIV_LO = 256,
  parameter int unsigned DIV_HI = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic run,
  input  logic clr,
  input  logic sel,
  output logic tick
);
  localparam int unsigned PW = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;
  localparam logic [PW-1:0] LIM_LO = PW'(DIV_LO - 1);
  localparam logic [PW-1:0] LIM_HI = PW'(DIV_HI - 1);

  logic [PW-1:0] pre_q, pre_d, lim;
  logic          step;

  always_comb begin
    lim  = sel ? LIM_HI : LIM_LO;
    step = run & clk_en;
    tick = step & (pre_q == lim);
    pre_d = pre_q;
    if (clr)       pre_d = '0;
    else if (tick) pre_d = '0;
    else if (step) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/wdg_access.sv
module wdg_access
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       lock,
  input  logic [3:0] key_nib,
  input  logic [3:0] usr_nib,
  input  logic [4:0] rsv_bits,
  input  logic [3:0] usr_key,
  output logic       mod_ok,
  output logic       acc_err
);
  acc_state_t st_q, st_d;

  always_comb begin
    st_d    = st_q;
    mod_ok  = 1'b0;
    acc_err = 1'b0;
    if (wr_en && !lock) begin
      unique case (st_q)
        ACC_IDLE: begin
          if (key_nib == KEY_FIXED && usr_nib == usr_key) st_d = ACC_OPEN;
          else acc_err = 1'b1;
        end
        ACC_OPEN: begin
          st_d = ACC_IDLE;
          if (key_nib == GUARD_KEY && rsv_bits == 5'd0) mod_ok = 1'b1;
          else acc_err = 1'b1;
        end
        default: st_d = ACC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ACC_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/guarded_wdog.sv
module guarded_wdog
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV_LO = 256,
  parameter int unsigned DIV_HI = 16384,
  parameter logic [15:0] FIX_RELOAD = 16'hFF00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic [1:0]       mode_o,
  output logic             endinit_o,
  output logic             rst_req_o,
  output logic [1:0]       err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_FIX = FIX_RELOAD[CNT_W-1:0];

  logic [CNT_W-1:0] cnt_q, cnt_d, rel_q, rel_d, wr_rel;
  wdg_mode_t        mode_q, mode_d;
  logic             init_q, init_d, stop_q, stop_d, psel_q, psel_d;
  logic             req_q, req_d;
  logic [3:0]       ukey_q, ukey_d;
  logic [1:0]       err_q, err_d;
  logic             lock, run, tick, mod_ok, acc_err;

  assign wr_rel = wr_data[31 -: CNT_W];
  assign lock   = req_q | (mode_q == MODE_PREWARN);
  assign run    = ~req_q & ((mode_q != MODE_NORMAL) | ~stop_q);

  wdg_access u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .lock     (lock),
    .key_nib  (wr_data[15:12]),
    .usr_nib  (wr_data[11:8]),
    .rsv_bits (wr_data[7:3]),
    .usr_key  (ukey_q),
    .mod_ok   (mod_ok),
    .acc_err  (acc_err)
  );

  wdg_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_en (clk_en),
    .run    (run),
    .clr    (acc_err | mod_ok),
    .sel    (psel_q),
    .tick   (tick)
  );

  always_comb begin
    cnt_d  = cnt_q;
    rel_d  = rel_q;
    mode_d = mode_q;
    init_d = init_q;
    stop_d = stop_q;
    psel_d = psel_q;
    req_d  = req_q;
    ukey_d = ukey_q;
    err_d  = err_q;
    if (!req_q) begin
      if (acc_err) begin
        mode_d = MODE_PREWARN;
        cnt_d  = CNT_FIX;
      end else if (mod_ok) begin
        rel_d  = wr_rel;
        ukey_d = wr_data[11:8];
        init_d = wr_data[BIT_INIT];
        stop_d = wr_data[BIT_STOP];
        psel_d = wr_data[BIT_PSEL];
        if (wr_data[BIT_INIT]) begin
          mode_d = MODE_NORMAL;
          cnt_d  = wr_rel;
        end else begin
          mode_d = MODE_TIMEOUT;
          cnt_d  = CNT_FIX;
        end
      end else if (tick) begin
        if (cnt_q == CNT_MAX) begin
          req_d = 1'b1;
          err_d = (mode_q == MODE_PREWARN) ? ERR_ACCESS : ERR_OVFL;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rel_q  <= '0;
      mode_q <= MODE_NORMAL;
      init_q <= 1'b1;
      stop_q <= 1'b0;
      psel_q <= 1'b0;
      req_q  <= 1'b0;
      ukey_q <= 4'd0;
      err_q  <= 2'b00;
    end else begin
      cnt_q  <= cnt_d;
      rel_q  <= rel_d;
      mode_q <= mode_d;
      init_q <= init_d;
      stop_q <= stop_d;
      psel_q <= psel_d;
      req_q  <= req_d;
      ukey_q <= ukey_d;
      err_q  <= err_d;
    end
  end

  assign count_o   = cnt_q;
  assign mode_o    = mode_q;
  assign endinit_o = init_q;
  assign rst_req_o = req_q;
  assign err_o     = err_q;
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_en,
  input logic             wr_en,
  input logic [CNT_W-1:0] count_o,
  input logic [1:0]       mode_o,
  input logic             rst_req_o,
  input logic [1:0]       err_o
);
  assert_req_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> rst_req_o);

  assert_count_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> $stable(count_o));

  assert_err_only_with_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o != 2'b00) |-> rst_req_o);

  assert_err_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> ($countones(err_o) == 1));

  assert_prewarn_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |=> (mode_o == 2'd2));

  assert_no_clock_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !wr_en) |=> $stable(count_o));

  assert_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));
endmodule

bind guarded_wdog wdg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_en    (clk_en),
  .wr_en     (wr_en),
  .count_o   (count_o),
  .mode_o    (mode_o),
  .rst_req_o (rst_req_o),
  .err_o     (err_o)
);

// File: tb/guarded_wdog_tb.sv
module guarded_wdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] FIX = 16'hFFF0;
  localparam int NVEC = 9;
  // {write data, mode, init flag, count}
  localparam logic [50:0] VEC [0:NVEC-1] = '{
    {32'h0000A000, 2'd0, 1'b1, 16'h0000},
    {32'h12345001, 2'd0, 1'b1, 16'h1234},
    {32'h0000A000, 2'd0, 1'b1, 16'h1234},
    {32'h00005000, 2'd1, 1'b0, FIX},
    {32'h0000A000, 2'd1, 1'b0, FIX},
    {32'hABCD5301, 2'd0, 1'b1, 16'hABCD},
    {32'h0000A000, 2'd2, 1'b1, FIX},
    {32'h0000A300, 2'd2, 1'b1, FIX},
    {32'hFFFF5300, 2'd2, 1'b1, FIX}
  };

  logic        clk, rst_n, clk_en, wr_en;
  logic [31:0] wr_data;
  logic [15:0] count_o;
  logic [1:0]  mode_o, err_o;
  logic        endinit_o, rst_req_o;
  int checks, fails;
  bit done;

  guarded_wdog #(.FIX_RELOAD(FIX)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en), .wr_data(wr_data),
    .count_o(count_o), .mode_o(mode_o), .endinit_o(endinit_o),
    .rst_req_o(rst_req_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; clk_en = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_en(input int n);
    @(negedge clk);
    clk_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    clk_en = 1'b0;
  endtask

  initial begin
    checks = 0; fails = 0; done = 0;
    do_reset();
    // R1 reset state
    check("R1 count", count_o, 0);
    check("R1 mode", mode_o, 0);
    check("R1 init", endinit_o, 1);
    check("R1 req/err", {rst_req_o, err_o}, 0);

    // Vector walk: R2 R3 R5 R6 R9 R11, clock enable low
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][50:19]);
      check($sformatf("R2/R5/R6/R11/R9 vec%0d mode", i), mode_o, VEC[i][18:17]);
      check($sformatf("R5/R6 vec%0d init", i), endinit_o, VEC[i][16]);
      check($sformatf("R3/R5 vec%0d count", i), count_o, VEC[i][15:0]);
      check($sformatf("R3 vec%0d no req", i), rst_req_o, 0);
    end

    // R4 bad guard
    do_reset();
    wr(32'h0000A000); wr(32'h12346001);
    check("R4 bad guard mode", mode_o, 2);
    check("R4 bad guard count", count_o, FIX);
    do_reset();
    wr(32'h0000A000); wr(32'h12345009);
    check("R4 reserved bits mode", mode_o, 2);

    // R12 FSM back to idle
    do_reset();
    wr(32'h0000A000); wr(32'h00105001);
    check("R12 first modify", count_o, 16'h0010);
    wr(32'h00205001);
    check("R12 modify without key", mode_o, 2);

    // R7 / R8 normal overflow with /256
    do_reset();
    wr(32'h0000A000); wr(32'hFFF05001);
    run_en(768);
    check("R7 three ticks", count_o, 16'hFFF3);
    repeat (100) @(negedge clk);
    check("R7 clk_en low hold", count_o, 16'hFFF3);
    run_en(3327);
    check("R8 just before overflow", {rst_req_o, count_o}, {1'b0, 16'hFFFF});
    run_en(1);
    check("R8 overflow req", rst_req_o, 1);
    check("R8 overflow flags", err_o, 2'b10);
    wr(32'h0000A000); wr(32'h00005001);
    run_en(300);
    check("R8 frozen after req", {rst_req_o, count_o, mode_o}, {1'b1, 16'hFFFF, 2'd0});

    // R7 /16384
    do_reset();
    wr(32'h0000A000); wr(32'hFFF05005);
    run_en(16383);
    check("R7 slow before tick", count_o, 16'hFFF0);
    run_en(1);
    check("R7 slow tick", count_o, 16'hFFF1);

    // R10 stop, then R9 prewarning overflow
    do_reset();
    wr(32'h0000A000); wr(32'h00005003);
    run_en(600);
    check("R10 stopped", count_o, 16'h0000);
    wr(32'h0000B000);
    check("R10 bad key while stopped", {mode_o, count_o}, {2'd2, FIX});
    run_en(256);
    check("R10 prewarn counts", count_o, FIX + 16'd1);
    run_en(3839);
    check("R9 before overflow", rst_req_o, 0);
    run_en(1);
    check("R9 prewarn req", rst_req_o, 1);
    check("R9 prewarn flags", err_o, 2'b01);

    // R6 time-out rescue and time-out overflow
    do_reset();
    wr(32'h0000A000); wr(32'h00005000);
    run_en(2000);
    check("R6 timeout counting", count_o, FIX + 16'd7);
    wr(32'h0000A000); wr(32'h00005001);
    check("R6 rescued", {mode_o, endinit_o, count_o}, {2'd0, 1'b1, 16'h0000});
    wr(32'h0000A000); wr(32'h00005000);
    run_en(4096);
    check("R6/R8 timeout overflow", {rst_req_o, err_o}, {1'b1, 2'b10});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule